// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the working state of a single DMA channel: a current memory offset, a count of transfer units still outstanding, and the base copies of both. Each accepted transfer strobe moves the offset one unit up or down and lowers the count by one. The engine combines the offset with a page value to form the physical byte address for the data path. The register file loads the base and current values through dedicated load strobes. The mode inputs choose the direction, the unit width (byte or word), whether data flows into memory, and whether the channel reloads itself when it reaches the end of a block.

A count value of C describes C+1 units. The unit that empties the counter raises a terminal-count pulse. With auto-initialize set, the channel then restarts from its base values and stays enabled. Without it, the channel moves past the last unit, parks its count at all ones, masks itself and raises a transfer-end pulse. Word channels address a 128K window: the word offset is doubled, and the lowest page bit is dropped. Arbitration, channel priority and the memory data path are outside this block.

Top module: `dma_addr_engine`

## Requirements
- R1: After reset the channel is masked (mask_o = 1), and current offset, current count and both base values are zero.
- R2: addr_ld_i writes addr_val_i into both the base and current offset, and cnt_ld_i writes cnt_val_i into both the base and current count, on the next clock edge. A load takes precedence over a transfer in the same cycle.
- R3: An accepted transfer (xfer_i high, channel unmasked, direction allowed) with a non-zero count raises the offset by 1 when decrement_i = 0 and lowers the count by 1, wrapping modulo 2^16.
- R4: With decrement_i = 1 on a byte channel reading from memory (to_mem_i = 0), an accepted transfer lowers the offset by 1, after the access at the unlowered offset.
- R5: tc_o is high, in the same cycle, for an accepted transfer made while the current count is zero, so a programmed count of C yields C+1 transfers before the pulse.
- R6: At terminal count with autoinit_i = 1, the current offset and count take their base values, and the mask stays unchanged.
- R7: At terminal count with autoinit_i = 0, end_o pulses with tc_o, the offset still steps past the last unit, the count becomes 16'hFFFF and mask_o becomes 1.
- R8: On a byte channel (chan16_i = 0), phys_addr_o = {page_i, current offset}.
- R9: On a word channel (chan16_i = 1), phys_addr_o = {page_i[7:1], current offset, 1'b0}, so the offset wraps inside a 128K window.
- R10: While mask_o = 1, xfer_i changes neither the offset nor the count, and tc_o and end_o stay low.
- R11: When decrement_i = 1 together with to_mem_i = 1 or chan16_i = 1, xfer_i is not accepted: the offset, count and mask stay unchanged.
- R12: mask_set_i sets the mask and mask_clr_i clears it on the next edge. A set, or a self-mask from R7, wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_ld_i | input | 1 | Load base and current offset |
| addr_val_i | input | 16 | Offset value to load |
| cnt_ld_i | input | 1 | Load base and current count |
| cnt_val_i | input | 16 | Count value to load (units minus one) |
| page_i | input | 8 | Page bits above the offset |
| autoinit_i | input | 1 | Reload from base values at terminal count |
| decrement_i | input | 1 | Step the offset downward |
| chan16_i | input | 1 | Word-wide channel |
| to_mem_i | input | 1 | Transfer writes into memory |
| mask_set_i | input | 1 | Set the channel mask |
| mask_clr_i | input | 1 | Clear the channel mask |
| xfer_i | input | 1 | One transfer unit requested this cycle |
| mask_o | output | 1 | Channel mask state |
| cur_addr_o | output | 16 | Current offset |
| cur_cnt_o | output | 16 | Current count |
| phys_addr_o | output | 24 | Physical byte address of the present unit |
| tc_o | output | 1 | Terminal-count pulse |
| end_o | output | 1 | Transfer-end pulse (terminal count without reload) |

## Verification
The hardest case to reach is terminal count in the same cycle as a boundary wrap. Examples are an auto-initialize block whose base offset sits just below 16'hFFFF, or a downward block that passes through zero. A short count must be programmed so that the counter empties near the wrap point. The directed stimulus loads such offsets with small counts and checks the reload and the step past the end. A long randomized stretch with frequent small loads then mixes mask, load and blocked-direction collisions. A cycle-level reference model checks every clock of that stretch.

// File: rtl/dma_addr_engine.sv
module dma_addr_engine #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_val_i,
  input  logic              cnt_ld_i,
  input  logic [ADDR_W-1:0] cnt_val_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              autoinit_i,
  input  logic              decrement_i,
  input  logic              chan16_i,
  input  logic              to_mem_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              xfer_i,
  output logic              mask_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] cur_cnt_o,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic              tc_o,
  output logic              end_o
);

  logic [ADDR_W-1:0] base_addr, base_cnt, cur_addr, cur_cnt, step_addr;
  logic              mask_q, blocked, go, last;

  assign blocked   = decrement_i & (to_mem_i | chan16_i);
  assign go        = xfer_i & ~mask_q & ~blocked;
  assign last      = (cur_cnt == '0);
  assign tc_o      = go & last;
  assign end_o     = tc_o & ~autoinit_i;
  assign step_addr = decrement_i ? cur_addr - 1'b1 : cur_addr + 1'b1;

  assign mask_o      = mask_q;
  assign cur_addr_o  = cur_addr;
  assign cur_cnt_o   = cur_cnt;
  assign phys_addr_o = chan16_i ? {page_i[PAGE_W-1:1], cur_addr, 1'b0}
                                : {page_i, cur_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mask_q    <= 1'b1;
    end else begin
      if (addr_ld_i) base_addr <= addr_val_i;
      if (cnt_ld_i)  base_cnt  <= cnt_val_i;

      if (addr_ld_i)
        cur_addr <= addr_val_i;
      else if (go)
        cur_addr <= (last && autoinit_i) ? base_addr : step_addr;

      if (cnt_ld_i)
        cur_cnt <= cnt_val_i;
      else if (go)
        cur_cnt <= !last ? cur_cnt - 1'b1 : (autoinit_i ? base_cnt : '1);

      if (mask_set_i || end_o)
        mask_q <= 1'b1;
      else if (mask_clr_i)
        mask_q <= 1'b0;
    end
  end

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && autoinit_i && !cnt_ld_i && !addr_ld_i)
      |=> (cur_cnt_o == base_cnt) && (cur_addr_o == base_addr));

  // R7
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o && !cnt_ld_i) |=> (mask_o && cur_cnt_o == '1));

  // R7
  end_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> tc_o);

  // R10
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o && !cnt_ld_i && !addr_ld_i)
      |=> ($stable(cur_cnt_o) && $stable(cur_addr_o)));

  // R11
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decrement_i && (to_mem_i || chan16_i) && !cnt_ld_i && !addr_ld_i)
      |=> ($stable(cur_cnt_o) && $stable(cur_addr_o)));

  // R12
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_i |=> mask_o);

endmodule

// File: tb/dma_addr_engine_bench.sv
`timescale 1ns/1ps
module dma_addr_engine_bench;
  logic clk = 0, rst_n = 0;
  logic addr_ld = 0, cnt_ld = 0, autoinit = 0, dec = 0, w16 = 0, tomem = 0;
  logic mset = 0, mclr = 0, xfer = 0;
  logic [15:0] aval = 0, cval = 0;
  logic [7:0] page = 0;
  logic mask_o, tc_o, end_o;
  logic [15:0] cur_addr_o, cur_cnt_o;
  logic [23:0] phys_o;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_addr_engine u_dma_addr_engine (
    .clk(clk), .rst_n(rst_n), .addr_ld_i(addr_ld), .addr_val_i(aval),
    .cnt_ld_i(cnt_ld), .cnt_val_i(cval), .page_i(page), .autoinit_i(autoinit),
    .decrement_i(dec), .chan16_i(w16), .to_mem_i(tomem), .mask_set_i(mset),
    .mask_clr_i(mclr), .xfer_i(xfer), .mask_o(mask_o), .cur_addr_o(cur_addr_o),
    .cur_cnt_o(cur_cnt_o), .phys_addr_o(phys_o), .tc_o(tc_o), .end_o(end_o));

  int m_ba, m_bc, m_ca, m_cc;
  bit m_mask;

  function automatic bit m_go();
    return xfer && !m_mask && !(dec && (tomem || w16));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ba = 0; m_bc = 0; m_ca = 0; m_cc = 0; m_mask = 1;
    end else begin
      bit g, t, e;
      g = m_go();
      t = g && (m_cc == 0);
      e = t && !autoinit;
      if (g) begin
        if (t && autoinit) begin m_ca = m_ba; m_cc = m_bc; end
        else begin
          m_ca = dec ? (m_ca + 65535) % 65536 : (m_ca + 1) % 65536;
          m_cc = t ? 65535 : m_cc - 1;
        end
      end
      if (addr_ld) begin m_ba = aval; m_ca = aval; end
      if (cnt_ld) begin m_bc = cval; m_cc = cval; end
      if (mset || e) m_mask = 1;
      else if (mclr) m_mask = 0;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    bit t;
    int ep;
    t = m_go() && (m_cc == 0);
    ep = w16 ? ((page >> 1) * 131072 + m_ca * 2) : (page * 65536 + m_ca);
    chk(cur_addr_o == m_ca[15:0], "R3 offset", cur_addr_o, m_ca);
    chk(cur_cnt_o == m_cc[15:0], "R3 count", cur_cnt_o, m_cc);
    chk(mask_o == m_mask, "R12 mask", mask_o, m_mask);
    chk(tc_o == t, "R5 tc", tc_o, t);
    chk(end_o == (t && !autoinit), "R7 end", end_o, t && !autoinit);
    if (w16) chk(phys_o == ep[23:0], "R9 phys16", phys_o, ep);
    else     chk(phys_o == ep[23:0], "R8 phys8", phys_o, ep);
  end

  task automatic tick();
    @(posedge clk); #1;
    addr_ld = 0; cnt_ld = 0; mset = 0; mclr = 0; xfer = 0;
  endtask

  task automatic setup(input int a, input int c);
    aval = a[15:0]; cval = c[15:0]; addr_ld = 1; cnt_ld = 1; mclr = 1;
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #9 rst_n = 1;
    @(negedge clk);
    chk(mask_o == 1, "R1 mask", mask_o, 1);
    chk(cur_addr_o == 0 && cur_cnt_o == 0, "R1 offset/count", {cur_addr_o, cur_cnt_o}, 0);
    @(posedge clk); #1;

    page = 8'h12;
    setup(16'h1234, 2);
    chk(cur_addr_o == 16'h1234 && cur_cnt_o == 2, "R2 load", {cur_addr_o, cur_cnt_o}, 32'h12340002);
    chk(mask_o == 0, "R12 clear", mask_o, 0);
    repeat (3) begin xfer = 1; tick(); end
    chk(cur_addr_o == 16'h1237, "R7 step past end", cur_addr_o, 16'h1237);
    chk(cur_cnt_o == 16'hFFFF, "R7 count parked", cur_cnt_o, 16'hFFFF);
    chk(mask_o == 1, "R7 self mask", mask_o, 1);
    xfer = 1; tick();
    chk(cur_addr_o == 16'h1237 && cur_cnt_o == 16'hFFFF, "R10 masked ignore",
        {cur_addr_o, cur_cnt_o}, 32'h1237FFFF);

    autoinit = 1;
    setup(16'hFFFE, 1);
    repeat (2) begin xfer = 1; tick(); end
    chk(cur_addr_o == 16'hFFFE && cur_cnt_o == 1, "R6 reload", {cur_addr_o, cur_cnt_o}, 32'hFFFE0001);
    chk(mask_o == 0, "R6 stays unmasked", mask_o, 0);
    repeat (3) begin xfer = 1; tick(); end
    autoinit = 0;

    dec = 1; tomem = 0;
    setup(16'h0001, 3);
    repeat (4) begin xfer = 1; tick(); end
    chk(cur_addr_o == 16'hFFFD, "R4 downward", cur_addr_o, 16'hFFFD);

    setup(16'h0040, 5);
    tomem = 1; xfer = 1; tick();
    chk(cur_addr_o == 16'h0040 && cur_cnt_o == 5, "R11 down into memory", {cur_addr_o, cur_cnt_o}, 32'h00400005);
    tomem = 0; w16 = 1; xfer = 1; tick();
    chk(cur_addr_o == 16'h0040 && cur_cnt_o == 5, "R11 down word", {cur_addr_o, cur_cnt_o}, 32'h00400005);
    dec = 0;

    page = 8'h35;
    setup(16'h8001, 4);
    @(negedge clk);
    chk(phys_o == 24'h350002, "R9 word address", phys_o, 24'h350002);
    setup(16'hFFFF, 4);
    xfer = 1; tick();
    chk(cur_addr_o == 16'h0000, "R9 word wrap", cur_addr_o, 0);
    w16 = 0;
    @(negedge clk);
    chk(phys_o == 24'h350000, "R8 byte address", phys_o, 24'h350000);
    @(posedge clk); #1;

    mset = 1; mclr = 1; tick();
    chk(mask_o == 1, "R12 set wins", mask_o, 1);

    for (int i = 0; i < 4000; i++) begin
      addr_ld = ($urandom % 16) == 0;
      cnt_ld  = ($urandom % 16) == 0;
      aval = ($urandom % 4 == 0) ? 16'hFFFF - $urandom % 3 : $urandom;
      cval = $urandom % 4;
      page = $urandom;
      autoinit = $urandom;
      dec = ($urandom % 3) == 0;
      w16 = ($urandom % 3) == 0;
      tomem = $urandom;
      mset = ($urandom % 12) == 0;
      mclr = ($urandom % 4) == 0;
      xfer = ($urandom % 3) != 0;
      @(posedge clk); #1;
    end
    addr_ld = 0; cnt_ld = 0; mset = 0; mclr = 0; xfer = 0;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule